// File: doc/BRIEF.md
# Multi-Region Address Range Checker

This block classifies memory access addresses against a small table of three regions: slot 0 holds code, slot 1 holds data and heap, and slot 2 holds the stack. Each region has an inclusive start and an exclusive end. For every request the block reports one of three outcomes. The request can fall into exactly one region, in which case the block gives the region index and the byte offset from that region's start. It can fall into several regions, which is an overlap error. Or it can fall into none, which is an uninitialized-access error. A request is either a single byte or a 32-bit word. A word counts only when all four of its bytes lie inside the same region.

Software sets up the table through a command port. A region can be defined in two ways. One gives an explicit start and end. The other gives only a start, and the end is then derived by rounding `start + 1` up to the next 16 MiB boundary. A third command moves the end of the code or data region upward. That command is refused when it would swallow the start of another region, when it targets the stack, or when it targets an undefined slot.

The block does not store data. When a request misses or is ambiguous, the block withholds its write-enable output, so a write is dropped, and it reports a zero offset.

Top module: `rgn_checker`

## Requirements
- R1: A byte request (`req_word`=0) falls into a defined region when start <= addr < end.
- R2: A word request (`req_word`=1) falls into a defined region only when start <= addr and addr + 4 <= end. A word that crosses a region end falls into that region not at all.
- R3: A request that falls into no region gives `rsp_miss`=1, `rsp_hit`=0, `rsp_region`=0, `rsp_offset`=0 and `rsp_we`=0.
- R4: A request that falls into two or more regions gives `rsp_overlap`=1, `rsp_hit`=0, `rsp_offset`=0 and `rsp_we`=0.
- R5: Command op 2 (auto span) sets the region to start `cmd_start` and end ((`cmd_start`+1) rounded up to a multiple of 0x1000000). The end is held with 33 bits, so a start near the top of the space ends at 2^32. Command op 1 (explicit span) sets the start to `cmd_start` and the end to `cmd_end`.
- R6: Command op 3 (grow) on slot 0 or 1 sets the end to `cmd_end` when `cmd_end` is above the current end. When `cmd_end` is at or below the current end, the region stays unchanged and `cmd_err` stays 0.
- R7: A grow on slot 2 or on an undefined region, and any command on a slot number of 3 or more, sets `cmd_err`=1 and changes no region.
- R8: A grow that would raise the end past the start of another defined region is refused with `cmd_err`=1. This applies when that other start is above the grown region's start and below `cmd_end`. The region stays unchanged.
- R9: Every response output is registered. The response to a request sampled at one clock edge is visible from that edge until the next one. `rsp_valid` follows `req_valid` by one cycle, and all flags are 0 when `rsp_valid` is 0.
- R10: On a single-region hit, `rsp_hit`=1, `rsp_region` is the slot number, `rsp_offset` = addr − start, and `rsp_we` equals `req_write`.
- R11: A command takes effect for requests from the next cycle on. A request in the same cycle as a command is checked against the old table. `cmd_err` is a one-cycle pulse one cycle after the command. Op 0 does nothing.
- R12: After reset all regions are undefined, so every request misses, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Table command strobe |
| cmd_op | input | 2 | 0 none, 1 explicit span, 2 auto span, 3 grow |
| cmd_slot | input | 2 | Target slot number |
| cmd_start | input | 32 | Region start for span commands |
| cmd_end | input | 32 | Region end for explicit span, new end for grow |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Access address |
| req_word | input | 1 | 1 = 32-bit word, 0 = byte |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Exactly one region matched |
| rsp_region | output | 2 | Matching slot number |
| rsp_offset | output | 32 | Address minus region start |
| rsp_overlap | output | 1 | More than one region matched |
| rsp_miss | output | 1 | No region matched |
| rsp_we | output | 1 | Write may proceed |
| cmd_err | output | 1 | Previous command refused |

## Verification
The response to a request and the `cmd_err` pulse for a command both appear one cycle after they are sampled. The bench drives each stimulus on a falling edge and reads the result on the next falling edge, half a period after the register has updated. The bench updates its region model only after that read. A request issued in the same cycle as a grow is therefore predicted against the table as it stood before the grow. The next request is predicted against the grown table.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    localparam int RGN_AW = 32;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SPAN = 2'd1,
        OP_AUTO = 2'd2,
        OP_GROW = 2'd3
    } rgn_op_e;

    typedef struct packed {
        logic              valid;
        logic [RGN_AW-1:0] start;
        logic [RGN_AW:0]   end_a;   // exclusive, one extra bit reaches 2^AW
    } region_t;

    // end for a region given only its start: (start+1) rounded up to 2^lg
    function automatic logic [RGN_AW:0] auto_end(input logic [RGN_AW-1:0] s,
                                                 input int unsigned lg);
        logic [RGN_AW:0] unit;
        logic [RGN_AW:0] bump;
        unit = (RGN_AW+1)'(1) << lg;
        bump = {1'b0, s} + unit;                // (s+1) + unit - 1
        return bump & ~(unit - (RGN_AW+1)'(1));
    endfunction

endpackage

// File: rtl/rgn_table.sv
module rgn_table
    import rgn_pkg::*;
#(
    parameter int NUM_SLOTS  = 3,
    parameter int GROW_SLOTS = 2,
    parameter int ALIGN_LOG2 = 24,
    parameter int SLOT_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [SLOT_W-1:0] cmd_slot,
    input  logic [RGN_AW-1:0] cmd_start,
    input  logic [RGN_AW-1:0] cmd_end,
    output region_t           regions [NUM_SLOTS],
    output logic              cmd_err
);

    rgn_op_e         op;
    region_t         cur;
    logic            slot_ok;
    logic            clash;
    logic            grow_bad;
    logic [RGN_AW:0] new_end;

    assign op      = rgn_op_e'(cmd_op);
    assign new_end = {1'b0, cmd_end};
    assign slot_ok = 32'(cmd_slot) < NUM_SLOTS;

    always_comb begin
        cur   = '0;
        clash = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (32'(cmd_slot) == i) cur = regions[i];
        end
        for (int j = 0; j < NUM_SLOTS; j++) begin
            if (regions[j].valid && 32'(cmd_slot) != j &&
                regions[j].start > cur.start && {1'b0, regions[j].start} < new_end)
                clash = 1'b1;
        end
        grow_bad = (32'(cmd_slot) >= GROW_SLOTS) || !cur.valid ||
                   ((new_end > cur.end_a) && clash);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_err <= 1'b0;
            for (int i = 0; i < NUM_SLOTS; i++) regions[i] <= '0;
        end else begin
            cmd_err <= cmd_valid && (op != OP_NONE) &&
                       (!slot_ok || (op == OP_GROW && grow_bad));
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (cmd_valid && 32'(cmd_slot) == i) begin
                    case (op)
                        OP_SPAN: regions[i] <= '{valid: 1'b1, start: cmd_start,
                                                 end_a: {1'b0, cmd_end}};
                        OP_AUTO: regions[i] <= '{valid: 1'b1, start: cmd_start,
                                                 end_a: auto_end(cmd_start, ALIGN_LOG2)};
                        OP_GROW: if (!grow_bad && new_end > cur.end_a)
                                     regions[i].end_a <= new_end;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R7: a non-growable slot keeps its end through a grow command
    generate
        for (genvar g = GROW_SLOTS; g < NUM_SLOTS; g++) begin : g_fixed
            assert_fixed_slot_R7: assert property (@(posedge clk) disable iff (rst)
                (cmd_valid && op == OP_GROW && 32'(cmd_slot) == g)
                |=> $stable(regions[g].end_a));
        end
        // R6: without a span command a region end never moves down
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mono
            assert_no_shrink_R6: assert property (@(posedge clk) disable iff (rst)
                !(cmd_valid && (op == OP_SPAN || op == OP_AUTO) && 32'(cmd_slot) == g)
                |=> regions[g].end_a >= $past(regions[g].end_a));
        end
    endgenerate

    // R8: a refused grow leaves the target end untouched
    assert_refused_grow_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_GROW && slot_ok && grow_bad && cmd_slot == 2'd0)
        |=> $stable(regions[0].end_a));

endmodule

// File: rtl/rgn_match.sv
module rgn_match
    import rgn_pkg::*;
#(
    parameter int NUM_SLOTS  = 3,
    parameter int WORD_BYTES = 4
) (
    input  region_t           regions [NUM_SLOTS],
    input  logic [RGN_AW-1:0] addr,
    input  logic              word,
    output logic [NUM_SLOTS-1:0] hits
);

    localparam logic [RGN_AW:0] WSPAN = (RGN_AW+1)'(WORD_BYTES);

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
            logic lo_ok;
            logic hi_ok;
            assign lo_ok = addr >= regions[i].start;
            assign hi_ok = word ? ({1'b0, addr} + WSPAN <= regions[i].end_a)
                                : ({1'b0, addr} < regions[i].end_a);
            assign hits[i] = regions[i].valid && lo_ok && hi_ok;
        end
    endgenerate

endmodule

// File: rtl/rgn_checker.sv
module rgn_checker
    import rgn_pkg::*;
#(
    parameter int NUM_SLOTS  = 3,
    parameter int GROW_SLOTS = 2,
    parameter int ALIGN_LOG2 = 24,
    parameter int WORD_BYTES = 4,
    parameter int SLOT_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [SLOT_W-1:0] cmd_slot,
    input  logic [31:0]       cmd_start,
    input  logic [31:0]       cmd_end,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_word,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [SLOT_W-1:0] rsp_region,
    output logic [31:0]       rsp_offset,
    output logic              rsp_overlap,
    output logic              rsp_miss,
    output logic              rsp_we,
    output logic              cmd_err
);

    localparam int CNT_W = $clog2(NUM_SLOTS + 1);

    region_t              regions [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] hits;
    logic [CNT_W-1:0]     n_hits;
    logic [SLOT_W-1:0]    hit_idx;
    logic [RGN_AW-1:0]    hit_off;
    logic                 single;

    rgn_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .GROW_SLOTS(GROW_SLOTS),
        .ALIGN_LOG2(ALIGN_LOG2),
        .SLOT_W    (SLOT_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_slot (cmd_slot),
        .cmd_start(cmd_start),
        .cmd_end  (cmd_end),
        .regions  (regions),
        .cmd_err  (cmd_err)
    );

    rgn_match #(
        .NUM_SLOTS (NUM_SLOTS),
        .WORD_BYTES(WORD_BYTES)
    ) u_match (
        .regions(regions),
        .addr   (req_addr),
        .word   (req_word),
        .hits   (hits)
    );

    always_comb begin
        n_hits  = '0;
        hit_idx = '0;
        hit_off = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hits[i]) begin
                n_hits  = n_hits + CNT_W'(1);
                hit_idx = SLOT_W'(i);
                hit_off = req_addr - regions[i].start;
            end
        end
        single = (n_hits == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_region  <= '0;
            rsp_offset  <= '0;
            rsp_overlap <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_we      <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_hit     <= req_valid && single;
            rsp_region  <= (req_valid && single) ? hit_idx : '0;
            rsp_offset  <= (req_valid && single) ? hit_off : '0;
            rsp_overlap <= req_valid && (n_hits > CNT_W'(1));
            rsp_miss    <= req_valid && (n_hits == '0);
            rsp_we      <= req_valid && single && req_write;
        end
    end

    // R9: response follows request by exactly one cycle
    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_overlap && !rsp_we);
    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_overlap}) == 1);
    // R3: a miss drops the write and reports no offset
    assert_miss_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> !rsp_we && rsp_offset == '0 && rsp_region == '0);
    // R4: an ambiguous address never enables a write
    assert_overlap_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_overlap |-> !rsp_we && rsp_offset == '0);
    // R10: write enable only for a clean single hit
    assert_we_needs_hit_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_we |-> rsp_hit && $past(req_write));

endmodule

// File: tb/rgn_checker_bench.sv
module rgn_checker_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [1:0]  cmd_slot;
    logic [31:0] cmd_start;
    logic [31:0] cmd_end;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_word;
    logic        req_write;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_region;
    logic [31:0] rsp_offset;
    logic        rsp_overlap;
    logic        rsp_miss;
    logic        rsp_we;
    logic        cmd_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model of the table
    bit          m_vld [3];
    logic [31:0] m_st  [3];
    logic [63:0] m_en  [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    rgn_checker u_rgn_checker (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_slot(cmd_slot),
        .cmd_start(cmd_start), .cmd_end(cmd_end),
        .req_valid(req_valid), .req_addr(req_addr), .req_word(req_word),
        .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_region(rsp_region),
        .rsp_offset(rsp_offset), .rsp_overlap(rsp_overlap), .rsp_miss(rsp_miss),
        .rsp_we(rsp_we), .cmd_err(cmd_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_auto_end(input logic [31:0] s);
        logic [63:0] unit = 64'h100_0000;
        return ((64'(s) + 64'd1 + unit - 64'd1) / unit) * unit;
    endfunction

    function automatic bit inside_rgn(input int i, input logic [31:0] a, input bit w);
        logic [63:0] top = 64'(a) + (w ? 64'd4 : 64'd1);
        return m_vld[i] && a >= m_st[i] && top <= m_en[i];
    endfunction

    // drive one request, read the registered response one cycle later
    task automatic send_req(input string tag, input logic [31:0] a, input bit w, input bit wr);
        int n = 0;
        int idx = 0;
        logic [31:0] off;
        for (int i = 0; i < 3; i++) if (inside_rgn(i, a, w)) begin n++; idx = i; end
        off = (n == 1) ? a - m_st[idx] : 32'd0;
        req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"},   64'(rsp_valid), 64'd1);
        check({tag, " hit"},     64'(rsp_hit), 64'(n == 1));
        check({tag, " miss"},    64'(rsp_miss), 64'(n == 0));
        check({tag, " overlap"}, 64'(rsp_overlap), 64'(n > 1));
        check({tag, " region"},  64'(rsp_region), (n == 1) ? 64'(idx) : 64'd0);
        check({tag, " offset"},  64'(rsp_offset), 64'(off));
        check({tag, " we"},      64'(rsp_we), 64'(n == 1 && wr));
    endtask

    function automatic bit model_grow_bad(input int s, input logic [63:0] ne);
        bit clash = 0;
        if (s >= 2 || !m_vld[s]) return 1;
        for (int j = 0; j < 3; j++)
            if (j != s && m_vld[j] && m_st[j] > m_st[s] && 64'(m_st[j]) < ne) clash = 1;
        return (ne > m_en[s]) && clash;
    endfunction

    task automatic apply_cmd(input int op, input int s, input logic [31:0] st, input logic [31:0] en);
        if (s > 2) return;
        case (op)
            1: begin m_vld[s] = 1; m_st[s] = st; m_en[s] = 64'(en); end
            2: begin m_vld[s] = 1; m_st[s] = st; m_en[s] = model_auto_end(st); end
            3: if (!model_grow_bad(s, 64'(en)) && 64'(en) > m_en[s]) m_en[s] = 64'(en);
            default: ;
        endcase
    endtask

    function automatic bit model_err(input int op, input int s, input logic [31:0] en);
        if (op == 0) return 0;
        if (s > 2) return 1;
        return (op == 3) && model_grow_bad(s, 64'(en));
    endfunction

    task automatic send_cmd(input string tag, input int op, input int s,
                            input logic [31:0] st, input logic [31:0] en);
        bit e = model_err(op, s, en);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_slot = 2'(s); cmd_start = st; cmd_end = en;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({tag, " cmd_err"}, 64'(cmd_err), 64'(e));
        apply_cmd(op, s, st, en);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) begin m_vld[i] = 0; m_st[i] = 0; m_en[i] = 0; end
        rst = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_slot = 0; cmd_start = 0; cmd_end = 0;
        req_valid = 0; req_addr = 0; req_word = 0; req_write = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state and empty table
        check("R12 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R12 cmd_err after reset", 64'(cmd_err), 64'd0);
        send_req("R12 empty table", 32'h0000_1000, 0, 1);

        // R5: auto and explicit spans
        send_cmd("R5 auto code", 2, 0, 32'h0000_1000, 32'h0);
        send_cmd("R5 span data", 1, 1, 32'h0800_0000, 32'h0800_1000);
        send_cmd("R5 auto stack", 2, 2, 32'hBF00_0000, 32'h0);
        send_req("R1 code first byte", 32'h0000_1000, 0, 1);
        send_req("R5 code last byte", 32'h00FF_FFFF, 0, 0);
        send_req("R5 code end miss", 32'h0100_0000, 0, 1);
        send_req("R1 below code", 32'h0000_0FFF, 0, 0);
        send_req("R2 last full word", 32'h00FF_FFFC, 1, 1);
        send_req("R2 straddling word", 32'h00FF_FFFD, 1, 1);
        send_req("R10 data hit", 32'h0800_0123, 0, 1);
        send_req("R10 stack top word", 32'hBFFF_FFFC, 1, 0);
        send_req("R3 hole write", 32'h5000_0000, 1, 1);

        // R6, R7, R8: grow rules
        send_cmd("R7 grow stack", 3, 2, 32'h0, 32'hC100_0000);
        send_req("R7 stack unchanged", 32'hC000_0000, 0, 0);
        send_cmd("R7 bad slot", 1, 3, 32'h0, 32'h10);
        send_cmd("R6 grow down", 3, 0, 32'h0, 32'h0080_0000);
        send_req("R6 code unchanged", 32'h00FF_FFFF, 0, 0);
        send_cmd("R8 grow over data", 3, 0, 32'h0, 32'h0900_0000);
        send_req("R8 code unchanged", 32'h0100_0000, 0, 0);
        send_cmd("R6 grow code", 3, 0, 32'h0, 32'h0200_0000);
        send_req("R6 code grown", 32'h01FF_FFFC, 1, 1);

        // R11: same-cycle request sees the old table
        cmd_valid = 1; cmd_op = 2'd3; cmd_slot = 2'd1; cmd_end = 32'h0800_2000;
        send_req("R11 same cycle old table", 32'h0800_1800, 0, 1);
        check("R11 grow accepted", 64'(cmd_err), 64'd0);
        apply_cmd(3, 1, 32'h0, 32'h0800_2000);
        send_req("R11 next cycle new table", 32'h0800_1800, 0, 1);
        send_cmd("R11 no-op command", 0, 1, 32'h0, 32'h0);

        // constrained random traffic and grows
        for (int k = 0; k < 600; k++) begin
            int sel = int'($urandom_range(0, 9));
            int s   = int'($urandom_range(0, 2));
            logic [31:0] a;
            if (sel < 4)      a = m_st[s] + 32'($urandom_range(0, 64)) - 32'd32;
            else if (sel < 8) a = 32'(m_en[s]) + 32'($urandom_range(0, 16)) - 32'd8;
            else              a = $urandom;
            if (sel == 9 && k % 3 == 0)
                send_cmd("R6 random grow", 3, int'($urandom_range(0, 2)), 32'h0,
                         32'(m_en[s]) + 32'($urandom_range(0, 32'h100_0000)) - 32'h80_0000);
            else
                send_req("R1 random", a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        // R4: overlapping regions; R5 at the top of the space
        send_cmd("R4 overlap stack", 1, 2, 32'h0800_0000, 32'h0800_0100);
        send_req("R4 ambiguous write", 32'h0800_0010, 0, 1);
        send_req("R4 ambiguous word", 32'h0800_00F0, 1, 0);
        send_req("R4 past overlap", 32'h0800_0100, 0, 1);
        send_cmd("R5 auto top", 2, 2, 32'hFFFF_FFF0, 32'h0);
        send_req("R5 top byte", 32'hFFFF_FFFF, 0, 1);
        send_req("R5 top word", 32'hFFFF_FFFC, 1, 1);
        send_req("R2 top straddle", 32'hFFFF_FFFE, 1, 0);

        // R12: reset clears the table again
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 3; i++) m_vld[i] = 0;
        send_req("R12 after second reset", 32'h0000_1000, 0, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule